// File: doc/BRIEF.md
# Sixteen-bit ALU with flag register

This block is the execute stage of a small 16-bit load/store processor. A 4-bit operation code picks one of eleven functions over two 16-bit operands, a 4-bit shift count and an 8-bit immediate. The 16-bit result is combinational. Three condition bits sit in a register: zero, signed overflow and negative. Only the add, subtract and bitwise operations may change them. A later conditional branch reads these bits, so the operations that do not define the bits must leave them untouched.

The first operand `opa` carries the source register. For the byte merge operations it carries the old value of the destination register. The second operand `opb` is used only by the two-operand operations. The flag register captures new values on a rising clock edge when `flag_we` is high and the current operation defines flags. The lane width, data width, shift-count width and immediate width are parameters, and elaboration checks that they agree with each other.

Top module: `alu_flag_unit`

## Requirements
- R1: Op 0000 gives opa AND opb, 0001 gives opa OR opb, 0010 gives opa XOR opb. Op 0011 gives the bitwise inverse of opa, and opb has no effect on it.
- R2: Op 0100 gives opa + opb and op 0101 gives opa - opb, both modulo 2^16 in two's complement.
- R3: On a flag write, an add or subtract sets flag_v exactly when signed overflow occurs. For add, the operands share a sign and the result sign differs. For subtract, the operand signs differ and the result sign differs from opa.
- R4: On a flag write, an add or subtract sets flag_z exactly when the result is 0 and sets flag_n exactly when result bit 15 is 1.
- R5: On a flag write, ops 0000 to 0011 set flag_z exactly when the result is 0 and always clear flag_v and flag_n, whatever the result's top bit.
- R6: Op 0110 shifts opa right arithmetically by shamt (0 to 15), copying bit 15 in. Op 0111 shifts opa left logically by shamt, filling with zeros.
- R7: Op 1100 adds bits 7:0 of the operands and bits 15:8 of the operands as two separate 8-bit sums. The carry out of the low byte never reaches the high byte.
- R8: Op 1010 gives {imm, opa[7:0]} and op 1011 gives {opa[15:8], imm}.
- R9: The flags change only on a rising edge where flag_we is 1 and op is one of 0000 to 0101. Shift, byte-add and merge ops leave the flags unchanged even with flag_we high.
- R10: A synchronous reset (rst high at a rising edge) clears all three flags. It overrides a flag write in the same cycle.
- R11: Ops 1000, 1001, 1101, 1110 and 1111 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code |
| opa | input | 16 | First operand, or old destination value for the byte merges |
| opb | input | 16 | Second operand |
| shamt | input | 4 | Unsigned shift count |
| imm | input | 8 | Byte immediate for the merges |
| flag_we | input | 1 | Flag write enable |
| result | output | 16 | Combinational result |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_n | output | 1 | Registered negative flag |

## Verification
The bench builds the block with its default parameters: 16-bit data, 8-bit lanes, a 4-bit shift count and an 8-bit immediate. With these values, shift counts of 0 and 15 and a lane carry at bit 7 are the real boundaries. The bench drives each of them directly: sign fill over a full 15-place shift, a low-byte overflow that must not reach the high byte, and overflow at both the positive and negative limits of add and subtract.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [3:0] {
      OPC_AND  = 4'b0000,
      OPC_OR   = 4'b0001,
      OPC_XOR  = 4'b0010,
      OPC_NOT  = 4'b0011,
      OPC_ADD  = 4'b0100,
      OPC_SUB  = 4'b0101,
      OPC_SRA  = 4'b0110,
      OPC_SLL  = 4'b0111,
      OPC_R8   = 4'b1000,
      OPC_R9   = 4'b1001,
      OPC_MHI  = 4'b1010,
      OPC_MLO  = 4'b1011,
      OPC_VADD = 4'b1100,
      OPC_RD   = 4'b1101,
      OPC_RE   = 4'b1110,
      OPC_RF   = 4'b1111
   } opc_e;

   typedef struct packed {
      logic z;
      logic v;
      logic n;
   } cond_t;

endpackage

// File: rtl/alu_lane_add.sv
// Adder split into independent lanes; carries stop at lane boundaries.
module alu_lane_add #(
   parameter int WIDTH = 16,
   parameter int LANES = 2
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum
);
   localparam int LW = WIDTH / LANES;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign sum[g*LW +: LW] = a[g*LW +: LW] + b[g*LW +: LW];
   end
endmodule

// File: rtl/alu_addsub.sv
// Full-width two's complement add/subtract with signed overflow detect.
module alu_addsub #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;
   logic [WIDTH-1:0] b_eff;

   assign b_eff = sub ? ~b : b;
   assign sum   = a + b_eff + {{(WIDTH-1){1'b0}}, sub};
   // b_eff's sign equals b's sign for add and its inverse for subtract
   assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/alu_shift.sv
// Logarithmic barrel shifter: one stage per bit of the shift count.
module alu_shift #(
   parameter int WIDTH = 16,
   parameter int SH_W  = 4
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SH_W-1:0]  amount,
   input  logic             left,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [SH_W+1];

   assign stg[0] = din;
   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int DIST = 1 << k;
      logic [WIDTH-1:0] moved;
      assign moved      = left ? (stg[k] << DIST)
                               : WIDTH'($signed(stg[k]) >>> DIST);
      assign stg[k+1]   = amount[k] ? moved : stg[k];
   end
   assign dout = stg[SH_W];
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu16_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  load,
   input  cond_t nxt,
   output cond_t cur
);
   always_ff @(posedge clk) begin
      if (rst)       cur <= '0;
      else if (load) cur <= nxt;
   end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int LANE_W  = 8,
   parameter int SHAMT_W = 4,
   parameter int IMM_W   = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [3:0]         op,
   input  logic [DATA_W-1:0]  opa,
   input  logic [DATA_W-1:0]  opb,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [IMM_W-1:0]   imm,
   input  logic               flag_we,
   output logic [DATA_W-1:0]  result,
   output logic               flag_z,
   output logic               flag_v,
   output logic               flag_n
);
   localparam int LANES = DATA_W / LANE_W;
   localparam int MSB   = DATA_W - 1;
   localparam int KEEP  = DATA_W - IMM_W;

   if (DATA_W % LANE_W != 0 || LANES < 2) begin : g_bad_lanes
      $error("DATA_W must hold two or more whole lanes");
   end
   if (IMM_W > DATA_W || IMM_W < 1) begin : g_bad_imm
      $error("IMM_W must lie in 1..DATA_W");
   end
   if ((1 << SHAMT_W) != DATA_W) begin : g_bad_sh
      $error("SHAMT_W must address every bit position of DATA_W");
   end

   opc_e             opc;
   logic [DATA_W-1:0] as_sum, lane_sum, sh_out;
   logic              as_ovf, is_logic, is_arith;
   cond_t             nxt_c, cur_c;

   assign opc = opc_e'(op);

   alu_addsub #(.WIDTH(DATA_W)) u_addsub (
      .a(opa), .b(opb), .sub(opc == OPC_SUB), .sum(as_sum), .ovf(as_ovf)
   );

   alu_lane_add #(.WIDTH(DATA_W), .LANES(LANES)) u_lanes (
      .a(opa), .b(opb), .sum(lane_sum)
   );

   alu_shift #(.WIDTH(DATA_W), .SH_W(SHAMT_W)) u_shift (
      .din(opa), .amount(shamt), .left(opc == OPC_SLL), .dout(sh_out)
   );

   always_comb begin
      unique case (opc)
         OPC_AND:          result = opa & opb;
         OPC_OR:           result = opa | opb;
         OPC_XOR:          result = opa ^ opb;
         OPC_NOT:          result = ~opa;
         OPC_ADD, OPC_SUB: result = as_sum;
         OPC_SRA, OPC_SLL: result = sh_out;
         OPC_VADD:         result = lane_sum;
         OPC_MHI:          result = {imm, opa[KEEP-1:0]};
         OPC_MLO:          result = {opa[MSB -: KEEP], imm};
         default:          result = '0;
      endcase
   end

   assign is_logic = (op[3:2] == 2'b00);
   assign is_arith = (opc == OPC_ADD) || (opc == OPC_SUB);

   assign nxt_c.z = (result == '0);
   assign nxt_c.v = is_arith & as_ovf;
   assign nxt_c.n = is_arith & result[MSB];

   alu_flag_reg u_flags (
      .clk(clk), .rst(rst), .load(flag_we & (is_logic | is_arith)),
      .nxt(nxt_c), .cur(cur_c)
   );

   assign flag_z = cur_c.z;
   assign flag_v = cur_c.v;
   assign flag_n = cur_c.n;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [3:0]        op,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic              flag_we,
   input logic [DATA_W-1:0] result,
   input logic              flag_z,
   input logic              flag_v,
   input logic              flag_n
);
   logic defines_flags;
   assign defines_flags = (op[3:2] == 2'b00) || (op == 4'b0100) || (op == 4'b0101);

   p_reset_clear_r10: assert property (@(posedge clk)
      rst |=> (!flag_z && !flag_v && !flag_n));

   p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !(flag_we && defines_flags) |=> $stable({flag_z, flag_v, flag_n}));

   p_logic_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (flag_we && op[3:2] == 2'b00) |=> (!flag_v && !flag_n));

   p_zero_track_r4: assert property (@(posedge clk) disable iff (rst)
      (flag_we && defines_flags) |=> (flag_z == ($past(result) == '0)));

   p_not_ignores_b_r1: assert property (@(posedge clk) disable iff (rst)
      (op == 4'b0011) |-> (result == ~opa));

   p_low_lane_r7: assert property (@(posedge clk) disable iff (rst)
      (op == 4'b1100) |-> (result[LANE_W-1:0] == LANE_W'(opa[LANE_W-1:0] + opb[LANE_W-1:0])));

   p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
      (op == 4'b1000 || op == 4'b1001 || op == 4'b1101 || op == 4'b1110 || op == 4'b1111)
      |-> (result == '0));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst(rst), .op(op), .opa(opa), .opb(opb), .flag_we(flag_we),
   .result(result), .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n)
);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op = 4'b0000;
   logic [15:0] opa = '0, opb = '0;
   logic [3:0]  shamt = '0;
   logic [7:0]  imm = '0;
   logic        flag_we = 1'b0;
   logic [15:0] result;
   logic        flag_z, flag_v, flag_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   alu_flag_unit i_alu_flag_unit (
      .clk(clk), .rst(rst), .op(op), .opa(opa), .opb(opb), .shamt(shamt),
      .imm(imm), .flag_we(flag_we), .result(result),
      .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic [15:0] a;
      logic [15:0] b;
      logic [3:0]  sh;
      logic [7:0]  im;
      logic [15:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{4'b0000, 16'hF0F0, 16'h3C3C, 4'd0, 8'h00, 16'h3030, 8'd1},  // R1 and
      '{4'b0001, 16'hF0F0, 16'h0F00, 4'd0, 8'h00, 16'hFFF0, 8'd1},  // R1 or
      '{4'b0010, 16'hFFFF, 16'h1234, 4'd0, 8'h00, 16'hEDCB, 8'd1},  // R1 xor
      '{4'b0011, 16'h00FF, 16'hABCD, 4'd0, 8'h00, 16'hFF00, 8'd1},  // R1 not
      '{4'b0011, 16'h00FF, 16'h5555, 4'd0, 8'h00, 16'hFF00, 8'd1},  // R1 not, other opb
      '{4'b0100, 16'h1234, 16'h1111, 4'd0, 8'h00, 16'h2345, 8'd2},  // R2 add
      '{4'b0101, 16'h1000, 16'h0001, 4'd0, 8'h00, 16'h0FFF, 8'd2},  // R2 sub
      '{4'b0101, 16'h0005, 16'h0007, 4'd0, 8'h00, 16'hFFFE, 8'd2},  // R2 sub wrap
      '{4'b0110, 16'h8000, 16'h0000, 4'd4, 8'h00, 16'hF800, 8'd6},  // R6 sra
      '{4'b0110, 16'h8001, 16'h0000, 4'd15,8'h00, 16'hFFFF, 8'd6},  // R6 sra max
      '{4'b0111, 16'h0001, 16'h0000, 4'd15,8'h00, 16'h8000, 8'd6},  // R6 sll max
      '{4'b0111, 16'h1234, 16'h0000, 4'd0, 8'h00, 16'h1234, 8'd6},  // R6 sll zero
      '{4'b1100, 16'h01FF, 16'h0101, 4'd0, 8'h00, 16'h0200, 8'd7},  // R7 low carry dropped
      '{4'b1100, 16'hFF80, 16'h0280, 4'd0, 8'h00, 16'h0100, 8'd7},  // R7 both lanes wrap
      '{4'b1010, 16'h1234, 16'h0000, 4'd0, 8'hAB, 16'hAB34, 8'd8},  // R8 high merge
      '{4'b1011, 16'h1234, 16'h0000, 4'd0, 8'hAB, 16'h12AB, 8'd8},  // R8 low merge
      '{4'b1000, 16'hFFFF, 16'hFFFF, 4'd3, 8'hFF, 16'h0000, 8'd11}, // R11
      '{4'b1111, 16'h1234, 16'h4321, 4'd1, 8'h11, 16'h0000, 8'd11}  // R11
   };

   task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_flags(string tag, logic [2:0] exp);
      checks++;
      if ({flag_z, flag_v, flag_n} !== exp) begin
         fails++;
         $display("FAIL %s actual zvn=%b expected zvn=%b", tag, {flag_z, flag_v, flag_n}, exp);
      end
   endtask

   // Drive one operation with the given enable; returns at the following negedge,
   // after the flag register has seen exactly one rising edge.
   task automatic step(logic [3:0] o, logic [15:0] a, logic [15:0] b, logic we);
      @(negedge clk);
      op = o; opa = a; opb = b; shamt = 4'd1; imm = 8'h00; flag_we = we;
      @(negedge clk);
      flag_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_flags("R10 reset state", 3'b000);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op = VECS[i].op; opa = VECS[i].a; opb = VECS[i].b;
         shamt = VECS[i].sh; imm = VECS[i].im; flag_we = 1'b0;
         #1;
         check16($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].exp);
      end
      check_flags("R9 no write while enable low", 3'b000);

      step(4'b0100, 16'h7FFF, 16'h0001, 1'b1);
      check_flags("R3 add positive overflow", 3'b011);
      step(4'b0101, 16'h8000, 16'h0001, 1'b1);
      check_flags("R3 sub negative overflow", 3'b010);
      step(4'b0100, 16'hFFFF, 16'h0001, 1'b1);
      check_flags("R4 add wraps to zero", 3'b100);
      step(4'b0101, 16'h0005, 16'h0007, 1'b1);
      check_flags("R4 sub negative no overflow", 3'b001);
      step(4'b0101, 16'h7FFF, 16'hFFFF, 1'b1);
      check_flags("R3 sub positive overflow", 3'b011);

      step(4'b0000, 16'h8000, 16'hFFFF, 1'b1);
      check_flags("R5 and clears v n with msb set", 3'b000);
      step(4'b0010, 16'h5A5A, 16'h5A5A, 1'b1);
      check_flags("R5 xor zero sets z", 3'b100);
      step(4'b0011, 16'hFFFF, 16'h1234, 1'b1);
      check_flags("R5 not of ones sets z", 3'b100);

      step(4'b0100, 16'h7FFF, 16'h0001, 1'b1);
      step(4'b0111, 16'h0000, 16'h0000, 1'b1);
      check_flags("R9 shift keeps flags", 3'b011);
      step(4'b1100, 16'h0000, 16'h0000, 1'b1);
      check_flags("R9 vector add keeps flags", 3'b011);
      step(4'b1011, 16'h0000, 16'h0000, 1'b1);
      check_flags("R9 merge keeps flags", 3'b011);
      step(4'b0100, 16'h0000, 16'h0000, 1'b0);
      check_flags("R9 add with enable low keeps flags", 3'b011);

      @(negedge clk);
      rst = 1'b1; op = 4'b0100; opa = 16'h7FFF; opb = 16'h0001; flag_we = 1'b1;
      @(negedge clk);
      rst = 1'b0; flag_we = 1'b0;
      check_flags("R10 reset beats write", 3'b000);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule